// File: doc/BRIEF.md
# Parity-Checked 16-Bit Serial Word Receiver

This block takes one asynchronous serial line and recovers 16-bit words from it. Each frame opens with a low start bit and carries sixteen data bits, least significant first. An even parity bit and a high stop bit close the frame. The bit period in clock cycles is fixed at elaboration from the clock frequency and the baud rate, so no divider is needed at run time. The line passes through a two-flop synchronizer. A falling edge seen while idle opens a frame, and every bit is sampled near its centre.

Incoming bits collect in a private scratch register. The visible word and its one-cycle valid strobe change only when the parity and stop checks both pass. A frame that fails either check raises a one-cycle error pulse and leaves the previously delivered word untouched. A reset synchronizer inside the block asserts reset at once and releases it on the clock.

Top module: `srx16_receiver`

## Requirements
- R1: A frame is a low start bit, 16 data bits sent least significant first, one parity bit and one high stop bit; the committed `rx_word` equals the 16 data bits with the first data bit at bit 0.
- R2: The line is synchronized through two flops. When the line falls just before clock edge k, the start edge is detected at edge k+2, and the outputs for that frame update at edge k+2+HALF+18*BIT.
- R3: A frame starts only on a high-to-low transition of the synchronized line while the receiver is idle; a line that stays low after a frame starts nothing new.
- R4: At HALF cycles after the start edge the line is checked again; if it is high, the receiver returns to idle and produces no output.
- R5: Parity is even: if the XOR of the 16 data bits and the parity bit is 1, `parity_err` pulses for one cycle and `rx_word_valid` stays low.
- R6: If the stop bit is sampled low, `frame_err` pulses for one cycle and `rx_word_valid` stays low; both error pulses may occur in the same cycle.
- R7: `rx_word_valid` is a single-cycle pulse, and `rx_word` changes only in a cycle where `rx_word_valid` is high.
- R8: After the stop-bit sample the receiver is idle and accepts a new start edge at once, even when the stop bit is shorter than a full period.
- R9: While reset is asserted, `rx_word` is zero and `rx_word_valid`, `parity_err` and `frame_err` are low.
- R10: BIT equals CLK_FREQ divided by BAUD_RATE and HALF equals BIT divided by 2; bit n after the start bit is sampled BIT*n cycles after the half-period check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_word | output | 16 | Last word that passed both checks |
| rx_word_valid | output | 1 | One-cycle pulse when `rx_word` is loaded |
| parity_err | output | 1 | One-cycle pulse on a parity failure |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The words cover alternating nibbles, all zeros, all ones and single set bits at both ends. Each pattern shows whether bit order and every bit position are recovered. Frames with a flipped parity bit, a low stop bit or both separate the two error paths, and the following good frame shows that the held word survived them. A short low glitch exercises the start re-check. A line that stays low after a frame shows that a level does not restart reception. Two frames with a shortened stop bit between them show that the receiver is idle again right after the stop sample.

// File: rtl/srx16_pkg.sv
package srx16_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } rx_state_e;

  function automatic int bit_clocks(input int clk_hz, input int baud);
    return clk_hz / baud;
  endfunction

endpackage

// File: rtl/srx_reset_sync.sv
module srx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_async,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= line_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b1;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign line_s    = stage_q[STAGES-1];
  assign line_fall = prev_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import srx16_pkg::*;
#(
  parameter int BIT_CLKS  = 16,
  parameter int HALF_CLKS = 8,
  parameter int DATA_W    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  input  logic line_fall,
  output logic take_data,
  output logic take_parity,
  output logic take_stop
);
  localparam int CW = $clog2(BIT_CLKS + 1);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CLKS - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_W - 1);

  rx_state_e       state_q, state_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [IW-1:0]   idx_q, idx_n;
  logic            half_hit, bit_hit;

  assign half_hit = (cnt_q == HALF_LAST);
  assign bit_hit  = (cnt_q == BIT_LAST);

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    idx_n       = idx_q;
    take_data   = 1'b0;
    take_parity = 1'b0;
    take_stop   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (line_fall) begin
          state_n = ST_START;
          cnt_n   = '0;
        end
      end
      ST_START: begin
        if (half_hit) begin
          cnt_n = '0;
          if (!line_s) begin
            state_n = ST_DATA;
            idx_n   = '0;
          end else begin
            state_n = ST_IDLE;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (bit_hit) begin
          cnt_n     = '0;
          take_data = 1'b1;
          if (idx_q == IDX_LAST) state_n = ST_PARITY;
          else                   idx_n   = idx_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_PARITY: begin
        if (bit_hit) begin
          cnt_n       = '0;
          take_parity = 1'b1;
          state_n     = ST_STOP;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (bit_hit) begin
          cnt_n     = '0;
          take_stop = 1'b1;
          state_n   = ST_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
    end
  end

  // R4: a high line at the half-period check sends the receiver back to idle
  p_glitch_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && half_hit && line_s) |=> (state_q == ST_IDLE));

  // R3: a frame is only ever entered from idle
  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) != ST_START) |-> ($past(state_q) == ST_IDLE));

  // R10: the bit counter never passes one bit period
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(BIT_CLKS));

  // R8: after the stop sample the receiver is idle on the next cycle
  p_idle_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_stop |=> (state_q == ST_IDLE));
endmodule

// File: rtl/srx_word_commit.sv
module srx_word_commit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              take_data,
  input  logic              take_parity,
  input  logic              take_stop,
  output logic [DATA_W-1:0] word,
  output logic              word_valid,
  output logic              par_err,
  output logic              stop_err
);
  logic [DATA_W-1:0] scratch_q;
  logic              par_bit_q;
  logic              par_bad, stop_bad, commit;

  assign par_bad  = ^{scratch_q, par_bit_q};
  assign stop_bad = ~line_s;
  assign commit   = take_stop & ~par_bad & ~stop_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
    end else if (take_data) begin
      scratch_q <= {line_s, scratch_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_bit_q <= 1'b0;
    end else if (take_parity) begin
      par_bit_q <= line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (commit) begin
      word <= scratch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      par_err    <= 1'b0;
      stop_err   <= 1'b0;
    end else begin
      word_valid <= commit;
      par_err    <= take_stop & par_bad;
      stop_err   <= take_stop & stop_bad;
    end
  end

  // R7: valid never lasts two cycles
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R7: the word only moves together with valid
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> word_valid);

  // R5 and R6: no commit alongside an error
  p_no_commit_on_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (!par_err && !stop_err));

  // R5: error pulses are one cycle wide
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> !par_err);

  // R6: framing error pulses are one cycle wide
  p_ferr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_err |=> !stop_err);
endmodule

// File: rtl/srx16_receiver.sv
module srx16_receiver
  import srx16_pkg::*;
#(
  parameter int CLK_FREQ    = 125_000_000,
  parameter int BAUD_RATE   = 7_812_500,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_serial,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_word_valid,
  output logic              parity_err,
  output logic              frame_err
);
  localparam int BIT_CLKS  = bit_clocks(CLK_FREQ, BAUD_RATE);
  localparam int HALF_CLKS = (BIT_CLKS / 2 > 0) ? BIT_CLKS / 2 : 1;

  logic rst_i_n;
  logic line_s, line_fall;
  logic take_data, take_parity, take_stop;

  srx_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .line_async (rx_serial),
    .line_s     (line_s),
    .line_fall  (line_fall)
  );

  srx_frame_ctrl #(
    .BIT_CLKS  (BIT_CLKS),
    .HALF_CLKS (HALF_CLKS),
    .DATA_W    (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .line_s      (line_s),
    .line_fall   (line_fall),
    .take_data   (take_data),
    .take_parity (take_parity),
    .take_stop   (take_stop)
  );

  srx_word_commit #(.DATA_W(DATA_W)) u_commit (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .line_s      (line_s),
    .take_data   (take_data),
    .take_parity (take_parity),
    .take_stop   (take_stop),
    .word        (rx_word),
    .word_valid  (rx_word_valid),
    .par_err     (parity_err),
    .stop_err    (frame_err)
  );

  // R9: outputs are quiet right after reset release
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (!rx_word_valid && !parity_err && !frame_err));
endmodule

// File: tb/tb_srx16_receiver.sv
module tb_srx16_receiver;
  localparam int CLK_FREQ  = 125_000_000;
  localparam int BAUD_RATE = 7_812_500;
  localparam int BIT       = CLK_FREQ / BAUD_RATE;
  localparam int HALF      = BIT / 2;
  localparam int LAT       = 3 + HALF + 18 * BIT;

  typedef struct {
    int          at;
    logic        v;
    logic        pe;
    logic        fe;
    logic [15:0] d;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_serial = 1'b1;
  logic [15:0] rx_word;
  logic        rx_word_valid, parity_err, frame_err;

  int   cyc = 0;
  int   vectors = 0;
  int   miscmp = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  ev_t  q[$];
  logic [15:0] exp_word = 16'h0000;
  logic [15:0] prev_word = 16'h0000;
  int   n_valid = 0, n_perr = 0, n_ferr = 0, n_silent_change = 0, n_long_valid = 0;
  logic prev_valid = 1'b0;

  srx16_receiver #(.CLK_FREQ(CLK_FREQ), .BAUD_RATE(BAUD_RATE)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_serial     (rx_serial),
    .rx_word       (rx_word),
    .rx_word_valid (rx_word_valid),
    .parity_err    (parity_err),
    .frame_err     (frame_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, expv);
    end
  endtask

  // Reference model: compared on every falling clock edge
  always @(negedge clk) begin
    if (mon_on) begin
      logic ev, epe, efe;
      ev = 1'b0; epe = 1'b0; efe = 1'b0;
      if (q.size() > 0 && q[0].at == cyc) begin
        ev_t e;
        e = q.pop_front();
        ev = e.v; epe = e.pe; efe = e.fe;
        if (e.v) exp_word = e.d;
      end
      chk(rx_word_valid == ev, "R2/R10", "valid timing", int'(rx_word_valid), int'(ev));
      chk(parity_err == epe, "R5", "parity_err", int'(parity_err), int'(epe));
      chk(frame_err == efe, "R6", "frame_err", int'(frame_err), int'(efe));
      chk(rx_word == exp_word, "R1", "rx_word", int'(rx_word), int'(exp_word));
      if (rx_word_valid) n_valid++;
      if (parity_err) n_perr++;
      if (frame_err) n_ferr++;
      if (rx_word != prev_word && !rx_word_valid) n_silent_change++;
      if (rx_word_valid && prev_valid) n_long_valid++;
      prev_word  = rx_word;
      prev_valid = rx_word_valid;
    end
  end

  task automatic idle(input int n);
    rx_serial = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // Drive one frame; stop_len shortens the stop bit when below BIT
  task automatic send(input logic [15:0] w, input bit flip_par, input logic stop_v,
                      input int stop_len);
    ev_t e;
    logic par;
    par = ^w ^ flip_par;
    e.at = cyc + LAT;
    e.v  = !flip_par && stop_v;
    e.pe = flip_par;
    e.fe = !stop_v;
    e.d  = w;
    q.push_back(e);
    rx_serial = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rx_serial = w[i];
      repeat (BIT) @(negedge clk);
    end
    rx_serial = par;
    repeat (BIT) @(negedge clk);
    rx_serial = stop_v;
    repeat (stop_len) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin : stim
    int base;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(rx_word == 16'h0, "R9", "word in reset", int'(rx_word), 0);
    chk(rx_word_valid == 1'b0, "R9", "valid in reset", int'(rx_word_valid), 0);
    chk(parity_err == 1'b0 && frame_err == 1'b0, "R9", "errors in reset",
        int'({parity_err, frame_err}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(10);

    // R1: assorted words
    send(16'hABCD, 0, 1'b1, BIT); idle(7);
    send(16'h1234, 0, 1'b1, BIT); idle(5);
    send(16'h0000, 0, 1'b1, BIT); idle(5);
    send(16'hFFFF, 0, 1'b1, BIT); idle(5);
    send(16'h8001, 0, 1'b1, BIT); idle(5);
    chk(n_valid == 5, "R1", "good frame count", n_valid, 5);

    // R5, R6: bad frames leave the word alone
    send(16'h5A5A, 1, 1'b1, BIT); idle(5);
    send(16'h0F0F, 0, 1'b0, BIT); idle(5);
    send(16'h1111, 1, 1'b0, BIT); idle(5);
    chk(n_perr == 2, "R5", "parity error count", n_perr, 2);
    chk(n_ferr == 2, "R6", "framing error count", n_ferr, 2);
    chk(rx_word == 16'h8001, "R5", "word held after errors", int'(rx_word), 16'h8001);

    // R4: short glitch is not a start bit
    base = n_valid + n_perr + n_ferr;
    rx_serial = 1'b0; repeat (3) @(negedge clk);
    idle(LAT + BIT);
    chk(n_valid + n_perr + n_ferr == base, "R4", "glitch output count",
        n_valid + n_perr + n_ferr, base);

    // R3: line held low after a frame starts nothing more
    send(16'h0000, 0, 1'b0, BIT);
    repeat (4 * BIT) @(negedge clk);
    idle(LAT);
    chk(n_ferr == 3, "R3", "framing errors with line held low", n_ferr, 3);
    chk(n_valid == 5, "R3", "no frame from low level", n_valid, 5);

    // R8: back-to-back frames with shortened stop
    send(16'hC3C3, 0, 1'b1, HALF + 2);
    send(16'h3C3C, 0, 1'b1, HALF + 2);
    send(16'h7E81, 0, 1'b1, BIT);
    idle(LAT);
    chk(n_valid == 8, "R8", "back-to-back commits", n_valid, 8);
    chk(rx_word == 16'h7E81, "R8", "last word", int'(rx_word), 16'h7E81);

    // R7: pulse width and word stability
    chk(n_long_valid == 0, "R7", "multi-cycle valid", n_long_valid, 0);
    chk(n_silent_change == 0, "R7", "word change without valid", n_silent_change, 0);
    chk(q.size() == 0, "R2", "pending expected events", q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule